// File: doc/BRIEF.md
# Timer Count-Clock Source Selector

This block decides, once per peripheral clock cycle, whether a 16-bit timer channel should advance. It holds a free-running prescaler whose counter bits act as divided internal clocks, and it brings four asynchronous clock pins into the peripheral domain through a synchronizer and an edge detector. A 3-bit source code picks one of these sources. A 2-bit edge code picks whether rising edges, falling edges or both edges of that source count. The result is a single-cycle count enable for the channel's counter. A second output, the source strobe, marks every edge seen on the selected source, whatever the edge code says.

A parameter picks the channel variant. Variant 0 maps the four upper source codes to the four pins. Variant 1 keeps the first two pins. Its third upper code selects a divide-by-256 tick, and its fourth passes through the overflow/underflow pulse of a neighbouring channel, which lets two channels be cascaded. Variant 1 also has a phase-counting mode, in which this selector produces no count at all. Internal and external sources read the edge code with opposite polarity.

Top module: `tmr_clksrc_sel`

## Requirements
- R1: The prescaler is an 8-bit counter that increments every cycle and is cleared by synchronous reset. Source codes 3'b001, 3'b010 and 3'b011 select square waves taken from counter bits 1, 3 and 5 (divide by 4, 16 and 64). An edge on the selected wave occurs in the cycle in which that bit has just changed.
- R2: In variant 0, codes 3'b100, 3'b101, 3'b110 and 3'b111 select pins ext_clk_pin[0], [1], [2] and [3]. The cascade input has no effect in this variant.
- R3: In variant 1, codes 3'b100 and 3'b101 select ext_clk_pin[0] and [1]. Code 3'b110 selects counter bit 7 (divide by 256), and ext_clk_pin[2] and [3] have no effect. Code 3'b111 makes count_en equal casc_pulse in the same cycle, whatever edge_sel holds.
- R4: For internal sources, edge_sel 2'b00 counts falling edges, 2'b01 counts rising edges, and 2'b10 or 2'b11 counts both edges.
- R5: For pin sources, edge_sel 2'b00 counts rising edges, 2'b01 counts falling edges, and 2'b10 or 2'b11 counts both edges.
- R6: Code 3'b000 selects the undivided clock. edge_sel 2'b00 gives no count. Every other edge_sel value gives a count in every cycle.
- R7: A pin change applied between clock edges shows up on count_en after the second following rising clock edge. It lasts exactly one cycle.
- R8: In variant 1, phase_mode high forces count_en and edge_strobe low for every source code. In variant 0, phase_mode has no effect.
- R9: edge_strobe is high in every cycle in which the selected source has an edge of either polarity. For the undivided clock it is high every cycle. For the cascade source it equals casc_pulse.
- R10: While rst is high, count_en and edge_strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Count source code |
| edge_sel | input | 2 | Counted-edge code |
| phase_mode | input | 1 | Channel in phase-counting mode (variant 1 only) |
| ext_clk_pin | input | 4 | Asynchronous external clock pins |
| casc_pulse | input | 1 | One-cycle overflow/underflow pulse from the neighbouring channel |
| count_en | output | 1 | Single-cycle count enable |
| edge_strobe | output | 1 | Any edge on the selected source |

## Verification
On every cycle, the embedded properties check several rules. The prescaler steps by one. No pin edge repeats in two consecutive cycles. Both-edge counting matches the strobe, and a count never comes without a strobe. A falling-edge code on the undivided clock never counts. In variant 1, the cascade pass-through holds and phase mode stays silent. Only the bench scenarios can show the actual division ratios, meaning the exact number of counts in a window after reset. They also show the two-edge synchronizer latency, the opposite edge-code polarity of pins versus internal ticks, and the fact that unused pins and the cascade input are ignored in the variant that does not select them.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Class of the currently selected count source
    typedef enum logic [1:0] {
        KIND_DIV1 = 2'd0,
        KIND_INT  = 2'd1,
        KIND_EXT  = 2'd2,
        KIND_CASC = 2'd3
    } src_kind_e;

    localparam int PIN_COUNT = 4;
    localparam int TAP_COUNT = 4;

    // Edge code interpretation shared by internal and pin sources.
    // Low edge-code bit XOR source polarity decides rising versus falling.
    function automatic logic pick_edge(input logic rise, input logic fall,
                                       input logic [1:0] esel, input logic is_pin);
        logic want_rise;
        want_rise = esel[0] ^ is_pin;
        if (esel[1])
            return rise | fall;
        return want_rise ? rise : fall;
    endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
    parameter int TAPS = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TAPS-1:0] tap_rise,
    output logic [TAPS-1:0] tap_fall
);
    localparam int CNT_W = 2 * TAPS;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [TAPS-1:0]  hist;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [TAPS-1:0] level;

    // Tap t is counter bit 2t+1: divide by 4^(t+1)
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign level[t] = st_q.cnt[2*t+1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.hist = level;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tap_rise = level & ~st_q.hist;
    assign tap_fall = ~level & st_q.hist;

    // R1: prescaler advances by one each cycle outside reset
    p_prescale_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/tcs_pin_sync.sv
module tcs_pin_sync #(
    parameter int NPIN   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][NPIN-1:0] stg;
        logic [NPIN-1:0]             hist;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
        st_d.hist = st_q.stg[STAGES-1];
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o = st_q.stg[STAGES-1] & ~st_q.hist;
    assign fall_o = ~st_q.stg[STAGES-1] & st_q.hist;

    // R7: a detected edge never lasts two cycles
    p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        (rise_o & $past(rise_o)) == '0);
    p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
        (fall_o & $past(fall_o)) == '0);

endmodule

// File: rtl/tcs_edge_qual.sv
module tcs_edge_qual
    import tcs_pkg::*;
(
    input  src_kind_e   kind,
    input  logic        rise_i,
    input  logic        fall_i,
    input  logic        casc_i,
    input  logic [1:0]  edge_sel,
    input  logic        inhibit,
    output logic        count_en,
    output logic        strobe
);
    always_comb begin
        count_en = 1'b0;
        strobe   = 1'b0;
        unique case (kind)
            KIND_DIV1: begin
                strobe   = 1'b1;
                count_en = (edge_sel != 2'b00);
            end
            KIND_INT: begin
                strobe   = rise_i | fall_i;
                count_en = pick_edge(rise_i, fall_i, edge_sel, 1'b0);
            end
            KIND_EXT: begin
                strobe   = rise_i | fall_i;
                count_en = pick_edge(rise_i, fall_i, edge_sel, 1'b1);
            end
            KIND_CASC: begin
                strobe   = casc_i;
                count_en = casc_i;
            end
            default: begin
                strobe   = 1'b0;
                count_en = 1'b0;
            end
        endcase
        if (inhibit) begin
            count_en = 1'b0;
            strobe   = 1'b0;
        end
    end

endmodule

// File: rtl/tmr_clksrc_sel.sv
module tmr_clksrc_sel
    import tcs_pkg::*;
#(
    parameter int CH_VARIANT  = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] src_sel,
    input  logic [1:0] edge_sel,
    input  logic       phase_mode,
    input  logic [3:0] ext_clk_pin,
    input  logic       casc_pulse,
    output logic       count_en,
    output logic       edge_strobe
);
    localparam bit HAS_CASC = (CH_VARIANT == 1);

    logic [TAP_COUNT-1:0] tap_rise, tap_fall;
    logic [PIN_COUNT-1:0] pin_rise, pin_fall;

    src_kind_e kind;
    logic      sel_rise, sel_fall;
    logic      inhibit;

    // Upper two source codes differ per variant
    src_kind_e hi6_kind, hi7_kind;
    logic      hi6_rise, hi6_fall, hi7_rise, hi7_fall;

    tcs_prescaler #(.TAPS(TAP_COUNT)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tap_rise (tap_rise),
        .tap_fall (tap_fall)
    );

    tcs_pin_sync #(.NPIN(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_clk_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    if (HAS_CASC) begin : g_cascade_variant
        assign hi6_kind = KIND_INT;
        assign hi6_rise = tap_rise[3];
        assign hi6_fall = tap_fall[3];
        assign hi7_kind = KIND_CASC;
        assign hi7_rise = 1'b0;
        assign hi7_fall = 1'b0;
    end else begin : g_pin_variant
        assign hi6_kind = KIND_EXT;
        assign hi6_rise = pin_rise[2];
        assign hi6_fall = pin_fall[2];
        assign hi7_kind = KIND_EXT;
        assign hi7_rise = pin_rise[3];
        assign hi7_fall = pin_fall[3];
    end

    always_comb begin
        kind     = KIND_INT;
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        unique case (src_sel)
            3'b000: kind = KIND_DIV1;
            3'b001: begin sel_rise = tap_rise[0]; sel_fall = tap_fall[0]; end
            3'b010: begin sel_rise = tap_rise[1]; sel_fall = tap_fall[1]; end
            3'b011: begin sel_rise = tap_rise[2]; sel_fall = tap_fall[2]; end
            3'b100: begin kind = KIND_EXT; sel_rise = pin_rise[0]; sel_fall = pin_fall[0]; end
            3'b101: begin kind = KIND_EXT; sel_rise = pin_rise[1]; sel_fall = pin_fall[1]; end
            3'b110: begin kind = hi6_kind; sel_rise = hi6_rise; sel_fall = hi6_fall; end
            3'b111: begin kind = hi7_kind; sel_rise = hi7_rise; sel_fall = hi7_fall; end
            default: kind = KIND_INT;
        endcase
    end

    assign inhibit = rst | (HAS_CASC & phase_mode);

    tcs_edge_qual u_qual (
        .kind     (kind),
        .rise_i   (sel_rise),
        .fall_i   (sel_fall),
        .casc_i   (casc_pulse),
        .edge_sel (edge_sel),
        .inhibit  (inhibit),
        .count_en (count_en),
        .strobe   (edge_strobe)
    );

    // Inputs that a given variant leaves unselected
    logic unused_ok;
    assign unused_ok = ^{phase_mode, casc_pulse, tap_rise, tap_fall, pin_rise, pin_fall};

    // R9: a count is always accompanied by a source strobe
    p_count_has_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        count_en |-> edge_strobe);

    // R6: falling-edge code on the undivided clock never counts
    p_div1_falling_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'b000 && edge_sel == 2'b00) |-> !count_en);

    if (HAS_CASC) begin : g_casc_checks
        // R8: phase-counting mode silences the selector
        p_phase_silent_r8: assert property (@(posedge clk) disable iff (rst)
            phase_mode |-> (!count_en && !edge_strobe));
        // R3: cascade pulse passes straight through
        p_cascade_pass_r3: assert property (@(posedge clk) disable iff (rst)
            (src_sel == 3'b111 && !phase_mode) |-> (count_en == casc_pulse));
        // R4: both-edge codes count every strobe
        p_both_edges_r4: assert property (@(posedge clk) disable iff (rst)
            (edge_sel[1] && src_sel != 3'b111) |-> (count_en == edge_strobe));
    end else begin : g_pin_checks
        // R5: both-edge codes count every strobe
        p_both_edges_r5: assert property (@(posedge clk) disable iff (rst)
            edge_sel[1] |-> (count_en == edge_strobe));
    end

endmodule

// File: tb/tmr_clksrc_sel_test.sv
module tmr_clksrc_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 256;
    localparam int NVEC       = 16;

    // {variant, src_sel, edge_sel, expected counts, expected strobes} over WINDOW cycles after reset
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 3'b000, 2'b00, 9'd0,   9'd256},
        {1'b0, 3'b000, 2'b01, 9'd256, 9'd256},
        {1'b0, 3'b000, 2'b10, 9'd256, 9'd256},
        {1'b0, 3'b001, 2'b00, 9'd63,  9'd127},
        {1'b0, 3'b001, 2'b01, 9'd64,  9'd127},
        {1'b0, 3'b001, 2'b11, 9'd127, 9'd127},
        {1'b0, 3'b010, 2'b00, 9'd15,  9'd31},
        {1'b0, 3'b010, 2'b01, 9'd16,  9'd31},
        {1'b0, 3'b011, 2'b00, 9'd3,   9'd7},
        {1'b0, 3'b011, 2'b01, 9'd4,   9'd7},
        {1'b0, 3'b011, 2'b10, 9'd7,   9'd7},
        {1'b1, 3'b110, 2'b01, 9'd1,   9'd1},
        {1'b1, 3'b110, 2'b00, 9'd0,   9'd1},
        {1'b1, 3'b110, 2'b11, 9'd1,   9'd1},
        {1'b1, 3'b001, 2'b01, 9'd64,  9'd127},
        {1'b0, 3'b110, 2'b01, 9'd0,   9'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_sel = 3'b000;
    logic [1:0] edge_sel = 2'b00;
    logic       phase_mode = 1'b0;
    logic [3:0] ext_clk_pin = 4'b0000;
    logic       casc_pulse = 1'b0;
    logic       en_a, stb_a, en_b, stb_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_clksrc_sel #(.CH_VARIANT(0)) uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .edge_sel(edge_sel),
        .phase_mode(phase_mode), .ext_clk_pin(ext_clk_pin), .casc_pulse(casc_pulse),
        .count_en(en_a), .edge_strobe(stb_a)
    );

    tmr_clksrc_sel #(.CH_VARIANT(1)) uut_v1 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .edge_sel(edge_sel),
        .phase_mode(phase_mode), .ext_clk_pin(ext_clk_pin), .casc_pulse(casc_pulse),
        .count_en(en_b), .edge_strobe(stb_b)
    );

    function automatic logic en_of(input bit v1);
        return v1 ? en_b : en_a;
    endfunction

    function automatic logic stb_of(input bit v1);
        return v1 ? stb_b : stb_a;
    endfunction

    task automatic check(input int actual, input int expected, input string req, input string what);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Called at a falling edge; reset held for two rising edges, released at a falling edge
    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one pin level at a falling edge; the count appears after the second rising edge (R7)
    task automatic pin_step(input int idx, input logic lvl, input logic exp_en,
                            input logic exp_stb, input bit v1, input string req);
        ext_clk_pin[idx] = lvl;
        #1;
        check(en_of(v1), 0, "R7", "count before first edge");
        @(negedge clk);
        check(en_of(v1), 0, "R7", "count after one edge");
        @(negedge clk);
        check(en_of(v1), exp_en, req, "count after two edges");
        check(stb_of(v1), exp_stb, "R9", "strobe after two edges");
        @(negedge clk);
        check(en_of(v1), 0, "R7", "count one cycle later");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);

        // Table walk: count pulses in a fixed window after reset
        for (int i = 0; i < NVEC; i++) begin
            bit         v1;
            int         cnt_en;
            int         cnt_stb;
            string      tag;
            v1       = VEC[i][23];
            src_sel  = VEC[i][22:20];
            edge_sel = VEC[i][19:18];
            cnt_en   = 0;
            cnt_stb  = 0;
            do_reset();
            #1;
            for (int k = 0; k < WINDOW; k++) begin
                cnt_en  += int'(en_of(v1));
                cnt_stb += int'(stb_of(v1));
                @(negedge clk);
            end
            if (src_sel == 3'b000)      tag = "R6";
            else if (v1)                tag = "R3";
            else if (src_sel[2])        tag = "R2";
            else                        tag = "R1 R4";
            check(cnt_en, int'(VEC[i][17:9]), tag, $sformatf("count total vector %0d", i));
            check(cnt_stb, int'(VEC[i][8:0]), "R9", $sformatf("strobe total vector %0d", i));
        end

        // R10: outputs low while reset is held, even on the undivided clock
        src_sel  = 3'b000;
        edge_sel = 2'b01;
        rst      = 1'b1;
        @(negedge clk);
        check(en_a, 0, "R10", "variant 0 count in reset");
        check(stb_a, 0, "R10", "variant 0 strobe in reset");
        check(en_b, 0, "R10", "variant 1 count in reset");
        rst = 1'b0;
        @(negedge clk);

        // R5: pin C on variant 0, edge polarity per code
        src_sel  = 3'b110;
        edge_sel = 2'b00;
        pin_step(2, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        edge_sel = 2'b01;
        pin_step(2, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        pin_step(2, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        edge_sel = 2'b10;
        pin_step(2, 1'b0, 1'b1, 1'b1, 1'b0, "R5");

        // R2: pin D on variant 0; R3 cascade on variant 1 under the same code
        src_sel  = 3'b111;
        edge_sel = 2'b00;
        pin_step(3, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        casc_pulse = 1'b1;
        #1;
        check(en_a, 0, "R2", "variant 0 ignores cascade");
        check(en_b, 1, "R3", "variant 1 cascade count");
        check(stb_b, 1, "R9", "variant 1 cascade strobe");
        @(negedge clk);
        casc_pulse = 1'b0;
        #1;
        check(en_b, 0, "R3", "variant 1 cascade idle");
        ext_clk_pin[3] = 1'b0;
        repeat (3) @(negedge clk);

        // R3: pin C ignored on variant 1 (divide-by-256 cannot tick this soon after reset)
        src_sel  = 3'b110;
        edge_sel = 2'b10;
        do_reset();
        ext_clk_pin[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(en_b, 0, "R3", "variant 1 ignores pin C");
        check(en_a, 1, "R2", "variant 0 counts pin C");
        ext_clk_pin[2] = 1'b0;
        repeat (3) @(negedge clk);

        // R3: pin A on variant 1
        src_sel  = 3'b100;
        edge_sel = 2'b00;
        pin_step(0, 1'b1, 1'b1, 1'b1, 1'b1, "R3");
        ext_clk_pin[0] = 1'b0;
        repeat (3) @(negedge clk);

        // R8: phase-counting mode
        phase_mode = 1'b1;
        src_sel    = 3'b000;
        edge_sel   = 2'b01;
        #1;
        check(en_a, 1, "R8", "variant 0 ignores phase mode");
        check(en_b, 0, "R8", "variant 1 count in phase mode");
        check(stb_b, 0, "R8", "variant 1 strobe in phase mode");
        @(negedge clk);
        src_sel    = 3'b111;
        casc_pulse = 1'b1;
        #1;
        check(en_b, 0, "R8", "variant 1 cascade in phase mode");
        @(negedge clk);
        casc_pulse = 1'b0;
        phase_mode = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule